// File: doc/BRIEF.md
# Extended-Header Cell Parser

This block takes a byte-serial cell stream and splits every cell into its parts. A cell opens with an optional user-defined prefix of 1 to 12 bytes. The 4-byte standard cell header follows, then an optional header check byte (HEC), then 48 payload bytes. The cell length is therefore 52 bytes, plus the prefix length, plus one byte when the check byte is present. The input marks the first byte of every cell with a start flag, and a valid strobe qualifies every byte.

The prefix length and the check-byte option are static settings. They are sampled only while reset is asserted and keep their values until the next reset. For each cell the block produces the following:
- the assembled 4-byte header word;
- a buffer holding the prefix bytes;
- a check-error flag;
- the payload as a byte stream with first-byte and last-byte marks.

A start flag that arrives before the current cell is complete abandons that cell and raises a length-error pulse.

Top module: `xcell_parser`

## Requirements
- R1: While reset is asserted, every output flag is low and the header word and prefix buffer read zero.
- R2: The prefix length and check-byte option are taken only on clock edges with reset asserted. Changes to them afterwards have no effect until the next reset. A prefix length above 12 is treated as 12.
- R3: With prefix length X and check flag H (0 or 1), the byte positions of a cell are laid out as follows. Position 0 carries the start flag. Positions 0..X-1 are the prefix. Positions X..X+3 are the standard header. Position X+4 is the check byte when H=1. The 48 payload bytes follow, and the cell holds 52+X+H bytes in total.
- R4: hdr_valid pulses for one cycle in the cycle after the last header byte is accepted. That byte is the check byte when H=1 and otherwise the fourth standard header byte. hdr_word then holds the first header byte received in bits 31:24, down to the fourth in bits 7:0.
- R5: Prefix byte i appears in xhdr_buf bits 8i+7:8i. Every buffer byte at an index of X or above reads zero, because the buffer is cleared at each start flag.
- R6: With H=1, the expected check byte is computed as follows. Run a CRC-8 with polynomial 0x07 and initial value 0, most significant bit first, over the 4 header bytes, then XOR the result with 0x55. hec_err is high alongside hdr_valid when the received check byte differs from this value. With H=0, hec_err stays low.
- R7: Each payload byte appears on pay_data with pay_valid high in the cycle after it is accepted. pay_sop marks the first payload byte and pay_eop marks the 48th.
- R8: A byte is accepted only in a cycle with in_valid high. Idle cycles inside a cell pause parsing without losing position.
- R9: While no cell is in progress, a valid byte without the start flag is discarded and produces no output.
- R10: A start flag on a byte while a cell is in progress drives len_err high for one cycle, in the cycle after that byte. That byte begins a new cell, and the abandoned cell never produces pay_eop.
- R11: After the last byte of a cell, the block waits for a start flag. A start flag on the very next byte begins a new cell without len_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; settings are sampled while it is low |
| cfg_xhdr_len | input | 4 | Prefix length in bytes, 0 to 12 |
| cfg_hec_en | input | 1 | Check byte present |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| hdr_valid | output | 1 | Header fields complete (one-cycle pulse) |
| hdr_word | output | 32 | Standard header, first byte in the top lane |
| xhdr_buf | output | 96 | Prefix bytes, byte i at bits 8i+7:8i |
| hec_err | output | 1 | Check byte mismatch, valid with hdr_valid |
| pay_valid | output | 1 | Payload byte valid |
| pay_sop | output | 1 | First payload byte |
| pay_eop | output | 1 | Last payload byte |
| pay_data | output | 8 | Payload byte |
| len_err | output | 1 | Cell cut short by an early start flag |

## Verification
The assertions assume that the settings stay put once reset is released and that reset is held for at least one clock edge. The bench sets the settings only inside its reset task. The single exception is one deliberate change without reset, whose lack of effect is checked at the outputs.

The assertions also assume that a start flag is seen only together with in_valid. The bench raises in_sop only on valid bytes, and returns both strobes to zero in every idle cycle. Idle gaps, abandoned cells and corrupted check bytes are drawn at random around these assumptions.

// File: rtl/xcell_pkg.sv
package xcell_pkg;

  localparam int unsigned STD_HDR_BYTES = 4;
  localparam logic [7:0]  HEC_POLY      = 8'h07;
  localparam logic [7:0]  HEC_COSET     = 8'h55;

  // One byte of a CRC-8, MSB first, polynomial x^8+x^2+x+1.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] din);
    logic [7:0] c;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ din[i]) c = {c[6:0], 1'b0} ^ HEC_POLY;
      else               c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/xcell_ctrl.sv
module xcell_ctrl
  import xcell_pkg::*;
#(
  parameter int unsigned XHDR_MAX  = 12,
  parameter int unsigned PAY_BYTES = 48,
  localparam int unsigned XL_W     = $clog2(XHDR_MAX + 1),
  localparam int unsigned CELL_MAX = XHDR_MAX + STD_HDR_BYTES + 1 + PAY_BYTES,
  localparam int unsigned POS_W    = $clog2(CELL_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XL_W-1:0] cfg_xlen_i,
  input  logic            cfg_hec_i,
  input  logic            in_valid,
  input  logic            in_sop,
  output logic            take_o,
  output logic            start_o,
  output logic            abort_o,
  output logic            last_o,
  output logic            is_xhdr_o,
  output logic            is_shdr_o,
  output logic            is_hec_o,
  output logic            is_pay_o,
  output logic            pay_first_o,
  output logic            hdr_done_o,
  output logic [XL_W-1:0] xidx_o,
  output logic [1:0]      sidx_o,
  output logic            hec_en_o
);

  logic [XL_W-1:0]  xlen_q;
  logic             hec_q;
  logic             busy_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos, xl_w, hdr_end, pay_at, last_at;

  // Settings sampled on edges with reset low; clamped to the prefix limit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlen_q <= (cfg_xlen_i > XL_W'(XHDR_MAX)) ? XL_W'(XHDR_MAX) : cfg_xlen_i;
      hec_q  <= cfg_hec_i;
    end
  end

  assign xl_w    = POS_W'(xlen_q);
  assign hdr_end = xl_w + POS_W'(3);
  assign pay_at  = xl_w + POS_W'(4) + POS_W'(hec_q);
  assign last_at = pay_at + POS_W'(PAY_BYTES - 1);

  assign start_o = in_valid && in_sop;
  assign take_o  = in_valid && (busy_q || in_sop);
  assign abort_o = start_o && busy_q;
  assign cur_pos = start_o ? '0 : pos_q;

  assign is_xhdr_o   = cur_pos < xl_w;
  assign is_shdr_o   = (cur_pos >= xl_w) && (cur_pos <= hdr_end);
  assign is_hec_o    = hec_q && (cur_pos == xl_w + POS_W'(4));
  assign is_pay_o    = cur_pos >= pay_at;
  assign pay_first_o = cur_pos == pay_at;
  assign last_o      = take_o && (cur_pos == last_at);
  assign hdr_done_o  = take_o && (hec_q ? is_hec_o : (cur_pos == hdr_end));
  assign xidx_o      = XL_W'(cur_pos);
  assign sidx_o      = 2'(cur_pos - xl_w);
  assign hec_en_o    = hec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (take_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        busy_q <= 1'b1;
        pos_q  <= cur_pos + POS_W'(1);
      end
    end
  end

  AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_xhdr_o, is_shdr_o, is_hec_o, is_pay_o})); // R3
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pos_q != '0) && (pos_q <= last_at)); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(xlen_q) && $stable(hec_q)); // R2
  AST_LAST_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !busy_q); // R11

endmodule

// File: rtl/xcell_hdr.sv
module xcell_hdr
  import xcell_pkg::*;
#(
  parameter int unsigned XHDR_MAX = 12,
  localparam int unsigned XL_W    = $clog2(XHDR_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic                  start,
  input  logic                  is_xhdr,
  input  logic                  is_shdr,
  input  logic                  is_hec,
  input  logic                  hdr_done,
  input  logic                  hec_en,
  input  logic [XL_W-1:0]       xidx,
  input  logic [1:0]            sidx,
  input  logic [7:0]            din,
  output logic                  hdr_valid,
  output logic [31:0]           hdr_word,
  output logic [XHDR_MAX*8-1:0] xhdr_buf,
  output logic                  hec_err
);

  logic [7:0]  crc_q;
  logic [7:0]  xb_q [XHDR_MAX];
  logic [31:0] word_q;
  logic        hv_q, he_q;
  logic [7:0]  hec_expect;
  logic        hec_mismatch;

  assign hec_expect   = crc_q ^ HEC_COSET;
  assign hec_mismatch = take && is_hec && (din != hec_expect);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      word_q <= '0;
      hv_q   <= 1'b0;
      he_q   <= 1'b0;
    end else begin
      if (take && is_shdr) begin
        crc_q <= crc8_step((sidx == 2'd0) ? 8'h00 : crc_q, din);
        for (int k = 0; k < 4; k++)
          if (sidx == 2'(k)) word_q[8*(3-k) +: 8] <= din;
      end
      hv_q <= hdr_done;
      he_q <= hdr_done && hec_en && hec_mismatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < XHDR_MAX; i++) xb_q[i] <= '0;
    end else begin
      for (int i = 0; i < XHDR_MAX; i++) begin
        if (take && is_xhdr && (xidx == XL_W'(i))) xb_q[i] <= din;
        else if (start)                             xb_q[i] <= '0;
      end
    end
  end

  for (genvar g = 0; g < XHDR_MAX; g++) begin : g_xlane
    assign xhdr_buf[8*g +: 8] = xb_q[g];
  end

  assign hdr_valid = hv_q;
  assign hdr_word  = word_q;
  assign hec_err   = he_q;

  AST_HEC_WITH_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    hec_err |-> hdr_valid); // R6
  AST_HEC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hec_en |-> !hec_err); // R6

endmodule

// File: rtl/xcell_pay.sv
module xcell_pay (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       is_pay,
  input  logic       pay_first,
  input  logic       last,
  input  logic [7:0] din,
  output logic       pay_valid,
  output logic       pay_sop,
  output logic       pay_eop,
  output logic [7:0] pay_data
);

  logic       pv_q, ps_q, pe_q;
  logic [7:0] pd_q;
  logic       pay_take;

  assign pay_take = take && is_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      ps_q <= 1'b0;
      pe_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= pay_take;
      ps_q <= pay_take && pay_first;
      pe_q <= pay_take && last;
      if (pay_take) pd_q <= din;
    end
  end

  assign pay_valid = pv_q;
  assign pay_sop   = ps_q;
  assign pay_eop   = pe_q;
  assign pay_data  = pd_q;

  AST_EOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pay_eop |-> pay_valid); // R7
  AST_SOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pay_sop |-> pay_valid); // R7

endmodule

// File: rtl/xcell_parser.sv
module xcell_parser
  import xcell_pkg::*;
#(
  parameter int unsigned XHDR_MAX  = 12,
  parameter int unsigned PAY_BYTES = 48,
  localparam int unsigned XL_W     = $clog2(XHDR_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [XL_W-1:0]       cfg_xhdr_len,
  input  logic                  cfg_hec_en,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic [7:0]            in_data,
  output logic                  hdr_valid,
  output logic [31:0]           hdr_word,
  output logic [XHDR_MAX*8-1:0] xhdr_buf,
  output logic                  hec_err,
  output logic                  pay_valid,
  output logic                  pay_sop,
  output logic                  pay_eop,
  output logic [7:0]            pay_data,
  output logic                  len_err
);

  logic            take, start, abort, last;
  logic            is_xhdr, is_shdr, is_hec, is_pay, pay_first, hdr_done, hec_en;
  logic [XL_W-1:0] xidx;
  logic [1:0]      sidx;
  logic            len_err_q;

  xcell_ctrl #(.XHDR_MAX(XHDR_MAX), .PAY_BYTES(PAY_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_xlen_i(cfg_xhdr_len), .cfg_hec_i(cfg_hec_en),
    .in_valid(in_valid), .in_sop(in_sop),
    .take_o(take), .start_o(start), .abort_o(abort), .last_o(last),
    .is_xhdr_o(is_xhdr), .is_shdr_o(is_shdr), .is_hec_o(is_hec), .is_pay_o(is_pay),
    .pay_first_o(pay_first), .hdr_done_o(hdr_done), .xidx_o(xidx), .sidx_o(sidx),
    .hec_en_o(hec_en)
  );

  xcell_hdr #(.XHDR_MAX(XHDR_MAX)) u_hdr (
    .clk(clk), .rst_n(rst_n), .take(take), .start(start),
    .is_xhdr(is_xhdr), .is_shdr(is_shdr), .is_hec(is_hec), .hdr_done(hdr_done),
    .hec_en(hec_en), .xidx(xidx), .sidx(sidx), .din(in_data),
    .hdr_valid(hdr_valid), .hdr_word(hdr_word), .xhdr_buf(xhdr_buf), .hec_err(hec_err)
  );

  xcell_pay u_pay (
    .clk(clk), .rst_n(rst_n), .take(take), .is_pay(is_pay), .pay_first(pay_first),
    .last(last), .din(in_data),
    .pay_valid(pay_valid), .pay_sop(pay_sop), .pay_eop(pay_eop), .pay_data(pay_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_err_q <= 1'b0;
    else        len_err_q <= abort;
  end

  assign len_err = len_err_q;

  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> len_err); // R10
  AST_ABORT_NO_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !pay_eop); // R10

endmodule

// File: tb/xcell_parser_tb.sv
`timescale 1ns/1ps
module xcell_parser_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_xhdr_len = '0;
  logic        cfg_hec_en = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        hdr_valid, hec_err, pay_valid, pay_sop, pay_eop, len_err;
  logic [31:0] hdr_word;
  logic [95:0] xhdr_buf;
  logic [7:0]  pay_data;

  int  n_chk = 0, n_bad = 0;
  bit  mid = 1'b0;
  bit  done = 1'b0;
  logic [7:0] cb [0:79];

  always #10 clk = ~clk;

  xcell_parser u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_xhdr_len(cfg_xhdr_len), .cfg_hec_en(cfg_hec_en),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .hdr_valid(hdr_valid), .hdr_word(hdr_word), .xhdr_buf(xhdr_buf), .hec_err(hec_err),
    .pay_valid(pay_valid), .pay_sop(pay_sop), .pay_eop(pay_eop), .pay_data(pay_data),
    .len_err(len_err)
  );

  // Check byte by polynomial long division of header*x^8 by 0x107.
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit s, input logic [7:0] d);
    in_valid = v; in_sop = s; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic quiet(input string req);
    check(!pay_valid && !hdr_valid && !len_err && !pay_eop, req, "quiet outputs",
          {pay_valid, hdr_valid, len_err, pay_eop}, 0);
  endtask

  task automatic do_reset(input logic [3:0] x, input bit h);
    rst_n = 1'b0;
    cfg_xhdr_len = x; cfg_hec_en = h;
    repeat (3) @(negedge clk);
    check(!hdr_valid && !hec_err && !pay_valid && !pay_sop && !pay_eop && !len_err
          && hdr_word == 0 && xhdr_buf == 0, "R1", "reset state",
          {hdr_valid, hec_err, pay_valid, pay_sop, pay_eop, len_err, hdr_word}, 0);
    rst_n = 1'b1;
    mid = 1'b0;
  endtask

  task automatic send_cell(input int x, input bit h, input bit bad,
                           input int nbytes, input bit gaps);
    int len  = 52 + x + int'(h);
    int pay0 = x + 4 + int'(h);
    logic [31:0] hw;
    logic [95:0] xe;
    for (int p = 0; p < len; p++) cb[p] = 8'($urandom);
    hw = {cb[x], cb[x+1], cb[x+2], cb[x+3]};
    if (h) cb[x+4] = ref_hec(hw) ^ (bad ? (8'h01 << ($urandom % 8)) : 8'h00);
    xe = '0;
    for (int i = 0; i < x; i++) xe[8*i +: 8] = cb[i];
    for (int p = 0; p < nbytes; p++) begin
      if (gaps && p > 0 && ($urandom % 4) == 0) begin
        step(1'b0, 1'b0, 8'($urandom));
        quiet("R8");
      end
      step(1'b1, p == 0, cb[p]);
      if (p == 0)
        check(len_err == mid, mid ? "R10" : "R11", "len_err at start", len_err, mid);
      if (p >= pay0)
        check(pay_valid && pay_data == cb[p] && pay_sop == (p == pay0)
              && pay_eop == (p == len - 1), "R7", "payload byte",
              {pay_valid, pay_sop, pay_eop, pay_data},
              {1'b1, p == pay0, p == len - 1, cb[p]});
      else
        check(!pay_valid, "R3", "no payload in header area", pay_valid, 0);
      check(hdr_valid == (p == pay0 - 1), "R4", "hdr_valid timing", hdr_valid, p == pay0 - 1);
      if (p == pay0 - 1) begin
        check(hdr_word == hw, "R4", "header word", hdr_word, hw);
        check(xhdr_buf == xe, "R5", "prefix buffer", xhdr_buf, xe);
        check(hec_err == (h && bad), "R6", "check byte error", hec_err, h && bad);
      end
      mid = (p != len - 1);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    // Standard layout with check byte.
    do_reset(4'd0, 1'b1);
    send_cell(0, 1'b1, 1'b0, 53, 1'b0);
    send_cell(0, 1'b1, 1'b1, 53, 1'b0);
    // R2: settings changed without reset are ignored.
    cfg_xhdr_len = 4'd5; cfg_hec_en = 1'b0;
    send_cell(0, 1'b1, 1'b0, 53, 1'b1);
    // Longest prefix, no check byte; stray bytes while idle (R9).
    do_reset(4'd12, 1'b0);
    send_cell(12, 1'b0, 1'b1, 64, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 8'($urandom));
      quiet("R9");
    end
    send_cell(12, 1'b0, 1'b0, 64, 1'b1);
    // R2: out-of-range length clamps to 12.
    do_reset(4'd15, 1'b1);
    send_cell(12, 1'b1, 1'b1, 65, 1'b0);
    // R10: early start in header and in payload, then complete cells (R11).
    do_reset(4'd1, 1'b1);
    send_cell(1, 1'b1, 1'b0, 3, 1'b0);
    send_cell(1, 1'b1, 1'b0, 30, 1'b0);
    send_cell(1, 1'b1, 1'b1, 54, 1'b0);
    send_cell(1, 1'b1, 1'b0, 54, 1'b0);
    // Random settings and cells.
    for (int r = 0; r < 8; r++) begin
      int x = int'($urandom % 13);
      bit h = 1'($urandom % 2);
      do_reset(4'(x), h);
      for (int c = 0; c < 6; c++) begin
        int len = 52 + x + int'(h);
        int nb  = (($urandom % 5) == 0) ? 1 + int'($urandom % (len - 1)) : len;
        send_cell(x, h, 1'($urandom % 2), nb, 1'b1);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule